// File: doc/BRIEF.md
# SPI Interrupt Status and Mask Bank

This block holds the interrupt register set of an SPI controller. It watches the fill levels of the transmit and receive FIFOs and a mode-fault line from the serial engine, turns them into events, latches those events into a status register, and raises one interrupt line whenever a latched event is also enabled in a mask. Software clears status bits by writing ones to them. It changes the mask only through a pair of write-only registers, one that sets bits and one that clears them. As a result, no register ever needs a read-modify-write.

A transmit watermark register sets the level below which the transmit FIFO counts as running low. The FIFOs (up to 128 entries) and the serial engine sit outside this block. The register port is a plain single-cycle bus. A write takes effect at the clock edge where `wr_en` is high. Reads are combinational on `rd_addr` and have no side effects. There is no back-pressure on either side.

Register indices: 0 status (read, write-one-to-clear), 1 mask set (write only), 2 mask clear (write only), 3 mask view (read only), 4 transmit watermark (read/write). All status and mask registers share one bit layout: bit 1 mode fault, bit 2 transmit below watermark, bit 3 transmit full, bit 4 receive not-empty.

Top module: `spi_irq_bank`

## Requirements
- R1: While `rst_n` is low, and directly after it is released, status reads 0, the mask view reads 0, the watermark reads 1 and `irq` is 0.
- R2: Status and mask use bit 1 for mode fault, bit 2 for transmit below watermark, bit 3 for transmit full and bit 4 for receive not-empty. Bits 0, 5 and 6 always read 0, and writing ones to them changes nothing.
- R3: Writing index 1 sets every mask bit whose data bit is 1 and leaves the other mask bits unchanged. Index 3 returns the current mask. Reads of indices 1 and 2 return 0.
- R4: Writing index 2 clears every mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R5: Status bits 1 to 3 latch their event at the clock edge where it is present, whether the bit is masked or not. They hold until a write of a one to that bit at index 0 clears them.
- R6: If an event is present at the same edge as a write-one-to-clear of its bit, the bit stays set.
- R7: Status bit 4 equals (`rx_level` != 0) as sampled at the previous edge. A write-one-to-clear does not remove it while the receive FIFO holds data.
- R8: Index 4 holds the watermark in its low 8 bits and resets to 1. The transmit-low event is present when `tx_level` is strictly less than the watermark, so a watermark of 0 never raises it.
- R9: The transmit-full event is present when `tx_level` equals the FIFO depth of 128.
- R10: `irq` is a register that takes the OR of (status AND mask) at each edge. It therefore goes high one cycle after a status bit latches under an enabled mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index for the write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Register index for the combinational read |
| rd_data | output | 8 | Read data |
| tx_level | input | 8 | Current transmit FIFO fill level |
| rx_level | input | 8 | Current receive FIFO fill level |
| mode_fault | input | 1 | Mode-fault indication from the serial engine |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is an event that coincides with the clear of its own bit. The stimulus holds a FIFO level at its triggering value through the edge on which the clear is written, and it does this both for a latched bit and for the receive bit. A second difficult case is a watermark write that lands at the same edge as a level already below the new threshold. The vector table handles it by holding the level steady across two edges, so the old threshold applies at the first edge and the new one at the second. The boundary where the level equals the watermark, a watermark of zero with an empty FIFO, and a full FIFO at exactly 128 entries each get their own vectors.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

  localparam int REG_W  = 7;
  localparam int ADDR_W = 3;

  localparam int B_MODF   = 1;
  localparam int B_TXLOW  = 2;
  localparam int B_TXFULL = 3;
  localparam int B_RXNE   = 4;

  localparam logic [REG_W-1:0] IMPL_MASK =
      REG_W'((1 << B_MODF) | (1 << B_TXLOW) | (1 << B_TXFULL) | (1 << B_RXNE));
  localparam logic [REG_W-1:0] LIVE_MASK = REG_W'(1 << B_RXNE);

  typedef enum logic [ADDR_W-1:0] {
    IDX_STATUS = 3'd0,
    IDX_MSET   = 3'd1,
    IDX_MCLR   = 3'd2,
    IDX_MVIEW  = 3'd3,
    IDX_WMARK  = 3'd4
  } reg_idx_e;

  typedef struct packed {
    logic [REG_W-1:0] st_clr;
    logic [REG_W-1:0] mk_set;
    logic [REG_W-1:0] mk_clr;
  } wr_cmd_t;

endpackage

// File: rtl/spi_irq_event_gen.sv
module spi_irq_event_gen
  import spi_irq_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             mode_fault,
  input  logic [LVL_W-1:0] wmark,
  output logic [REG_W-1:0] events
);

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  // Event vector in the shared status layout; unused positions stay 0.
  always_comb begin
    events           = '0;
    events[B_MODF]   = mode_fault;
    events[B_TXLOW]  = (tx_level < wmark);
    events[B_TXFULL] = (tx_level == FULL_LVL);
    events[B_RXNE]   = (rx_level != '0);
  end

endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
#(
  parameter logic [REG_W-1:0] IMPL = IMPL_MASK,
  parameter logic [REG_W-1:0] LIVE = LIVE_MASK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] events,
  input  logic [REG_W-1:0] clr,
  output logic [REG_W-1:0] status
);

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (!IMPL[i]) begin : g_none
      assign status[i] = 1'b0;
    end else if (LIVE[i]) begin : g_live
      // Level-type bit: mirrors its condition, a clear has no lasting effect.
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= events[i];
      end
      assign status[i] = bit_q;

      p_live_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status[i] == $past(events[i])));
    end else begin : g_sticky
      // Sticky bit: set by its event, cleared by a written one; event wins.
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= events[i] | (bit_q & ~clr[i]);
      end
      assign status[i] = bit_q;

      p_event_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        events[i] |=> status[i]);
      p_w1c_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[i] && !events[i]) |=> !status[i]);
      p_sticky_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr[i] && !events[i]) |=> $stable(status[i]));
    end
  end

endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask
  import spi_irq_pkg::*;
#(
  parameter logic [REG_W-1:0] IMPL = IMPL_MASK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_bits,
  input  logic [REG_W-1:0] clr_bits,
  output logic [REG_W-1:0] mask
);

  logic [REG_W-1:0] mask_q;

  // Set and clear come from different indices and never coincide;
  // clear is applied last should both ever be non-zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= ((mask_q | set_bits) & ~clr_bits) & IMPL;
  end

  assign mask = mask_q;

  p_mask_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_bits == '0) |=> ((mask & $past(set_bits & IMPL)) == $past(set_bits & IMPL)));
  p_mask_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_bits != '0) |=> ((mask & $past(clr_bits)) == '0));
  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_bits == '0 && clr_bits == '0) |=> $stable(mask));

endmodule

// File: rtl/spi_irq_regif.sv
module spi_irq_regif
  import spi_irq_pkg::*;
#(
  parameter int LVL_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [REG_W-1:0]  status,
  input  logic [REG_W-1:0]  mask,
  output wr_cmd_t           cmd,
  output logic [LVL_W-1:0]  wmark,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [LVL_W-1:0] WM_RESET = LVL_W'(1);

  logic [LVL_W-1:0] wm_q;
  logic [REG_W-1:0] wbits;

  assign wbits = wr_data[REG_W-1:0] & IMPL_MASK;

  always_comb begin
    cmd = '0;
    if (wr_en) begin
      unique case (wr_addr)
        IDX_STATUS: cmd.st_clr = wbits;
        IDX_MSET:   cmd.mk_set = wbits;
        IDX_MCLR:   cmd.mk_clr = wbits;
        default:    cmd = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                wm_q <= WM_RESET;
    else if (wr_en && wr_addr == IDX_WMARK)   wm_q <= wr_data[LVL_W-1:0];
  end

  assign wmark = wm_q;

  // Side-effect-free read mux; write-only indices read as zero.
  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      IDX_STATUS: rd_data = DATA_W'(status);
      IDX_MVIEW:  rd_data = DATA_W'(mask);
      IDX_WMARK:  rd_data = DATA_W'(wm_q);
      default:    rd_data = '0;
    endcase
  end

  p_wo_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == IDX_MSET || rd_addr == IDX_MCLR) |-> (rd_data == '0));
  p_wm_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == IDX_WMARK) |=> (wmark == $past(wr_data[LVL_W-1:0])));

endmodule

// File: rtl/spi_irq_bank.sv
module spi_irq_bank
  import spi_irq_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int LVL_W  = $clog2(DEPTH + 1),
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              mode_fault,
  output logic              irq
);

  wr_cmd_t          cmd;
  logic [LVL_W-1:0] wmark;
  logic [REG_W-1:0] events;
  logic [REG_W-1:0] status;
  logic [REG_W-1:0] mask;
  logic             irq_q;

  spi_irq_regif #(.LVL_W(LVL_W), .DATA_W(DATA_W)) u_regif (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .status  (status),
    .mask    (mask),
    .cmd     (cmd),
    .wmark   (wmark),
    .rd_data (rd_data)
  );

  spi_irq_event_gen #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_events (
    .tx_level   (tx_level),
    .rx_level   (rx_level),
    .mode_fault (mode_fault),
    .wmark      (wmark),
    .events     (events)
  );

  spi_irq_status #(.IMPL(IMPL_MASK), .LIVE(LIVE_MASK)) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .events (events),
    .clr    (cmd.st_clr),
    .status (status)
  );

  spi_irq_mask #(.IMPL(IMPL_MASK)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_bits (cmd.mk_set),
    .clr_bits (cmd.mk_clr),
    .mask     (mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(status & mask);
  end

  assign irq = irq_q;

  p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(status & mask) != '0));
  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |=> !irq);
  p_full_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == LVL_W'(DEPTH)) |=> status[B_TXFULL]);
  p_low_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level < wmark) |=> status[B_TXLOW]);
  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((status | mask) & ~IMPL_MASK) == '0);

endmodule

// File: tb/tb_spi_irq_bank.sv
`timescale 1ns/1ps
module tb_spi_irq_bank;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [7:0] tx_level = 8'd64;
  logic [7:0] rx_level = 8'd0;
  logic       mode_fault = 1'b0;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  spi_irq_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tx_level(tx_level), .rx_level(rx_level), .mode_fault(mode_fault),
    .irq(irq)
  );

  typedef struct packed {
    logic       wr;
    logic [2:0] addr;
    logic [7:0] data;
    logic [7:0] txl;
    logic [7:0] rxl;
    logic       mf;
    logic [6:0] st;
    logic [6:0] mk;
    logic       irq;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VT [NV] = '{
    '{1'b0, 3'd0, 8'h00, 8'd64,  8'd0, 1'b0, 7'h00, 7'h00, 1'b0, 4'd1},  // R1 idle
    '{1'b0, 3'd0, 8'h00, 8'd64,  8'd0, 1'b1, 7'h02, 7'h00, 1'b0, 4'd5},  // R5 latch while masked
    '{1'b1, 3'd1, 8'h02, 8'd64,  8'd0, 1'b0, 7'h02, 7'h02, 1'b1, 4'd3},  // R3 set mask
    '{1'b1, 3'd0, 8'h02, 8'd64,  8'd0, 1'b0, 7'h00, 7'h02, 1'b0, 4'd5},  // R5 W1C
    '{1'b0, 3'd0, 8'h00, 8'd0,   8'd0, 1'b0, 7'h04, 7'h02, 1'b0, 4'd8},  // R8 below wm 1
    '{1'b1, 3'd1, 8'h7F, 8'd64,  8'd0, 1'b0, 7'h04, 7'h1E, 1'b1, 4'd2},  // R2 unused mask bits
    '{1'b1, 3'd0, 8'h04, 8'd0,   8'd0, 1'b0, 7'h04, 7'h1E, 1'b1, 4'd6},  // R6 event wins
    '{1'b1, 3'd0, 8'h04, 8'd64,  8'd0, 1'b0, 7'h00, 7'h1E, 1'b0, 4'd5},  // R5 clear
    '{1'b0, 3'd0, 8'h00, 8'd64,  8'd5, 1'b0, 7'h10, 7'h1E, 1'b1, 4'd7},  // R7 rx data
    '{1'b1, 3'd0, 8'h10, 8'd64,  8'd5, 1'b0, 7'h10, 7'h1E, 1'b1, 4'd7},  // R7 W1C no effect
    '{1'b0, 3'd0, 8'h00, 8'd64,  8'd0, 1'b0, 7'h00, 7'h1E, 1'b0, 4'd7},  // R7 drained
    '{1'b0, 3'd0, 8'h00, 8'd128, 8'd0, 1'b0, 7'h08, 7'h1E, 1'b1, 4'd9},  // R9 full
    '{1'b1, 3'd2, 8'h08, 8'd64,  8'd0, 1'b0, 7'h08, 7'h16, 1'b0, 4'd4},  // R4 clear mask
    '{1'b1, 3'd0, 8'h7F, 8'd64,  8'd0, 1'b0, 7'h00, 7'h16, 1'b0, 4'd2},  // R2 W1C all
    '{1'b1, 3'd4, 8'd100, 8'd64, 8'd0, 1'b0, 7'h04, 7'h16, 1'b0, 4'd8},  // R8 new wm 100
    '{1'b1, 3'd0, 8'h04, 8'd100, 8'd0, 1'b0, 7'h00, 7'h16, 1'b0, 4'd8},  // R8 equal: no event
    '{1'b0, 3'd0, 8'h00, 8'd99,  8'd0, 1'b0, 7'h04, 7'h16, 1'b1, 4'd10}, // R10 irq
    '{1'b1, 3'd0, 8'h04, 8'd99,  8'd0, 1'b0, 7'h04, 7'h16, 1'b1, 4'd6}   // R6 event wins
  };

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic read_reg(input logic [2:0] a, output logic [7:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wr_cycle(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] v;
    // R1 reset state, while held and after release
    #5;
    read_reg(3'd0, v); check("R1", "status in reset", v, 8'h00);
    read_reg(3'd4, v); check("R1", "wmark in reset", v, 8'h01);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    read_reg(3'd0, v); check("R1", "status after reset", v, 8'h00);
    read_reg(3'd3, v); check("R1", "mask after reset", v, 8'h00);
    read_reg(3'd4, v); check("R1", "wmark after reset", v, 8'h01);
    check("R1", "irq after reset", {7'd0, irq}, 8'h00);

    for (int k = 0; k < NV; k++) begin
      string rq;
      rq = $sformatf("R%0d", VT[k].req);
      @(negedge clk);
      wr_en = VT[k].wr; wr_addr = VT[k].addr; wr_data = VT[k].data;
      tx_level = VT[k].txl; rx_level = VT[k].rxl; mode_fault = VT[k].mf;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      @(posedge clk);
      @(negedge clk);
      read_reg(3'd0, v); check(rq, $sformatf("vec %0d status", k), v, {1'b0, VT[k].st});
      read_reg(3'd3, v); check(rq, $sformatf("vec %0d mask", k), v, {1'b0, VT[k].mk});
      check(rq, $sformatf("vec %0d irq", k), {7'd0, irq}, {7'd0, VT[k].irq});
    end

    // R8 watermark readback, then zero watermark never flags an empty FIFO
    read_reg(3'd4, v); check("R8", "wmark readback", v, 8'd100);
    wr_cycle(3'd4, 8'd0);
    tx_level = 8'd0;
    wr_cycle(3'd0, 8'h04);
    @(posedge clk); @(negedge clk);
    read_reg(3'd0, v); check("R8", "wm 0 empty fifo", v, 8'h00);
    read_reg(3'd4, v); check("R8", "wmark zero readback", v, 8'h00);
    tx_level = 8'd64;

    // R3 write-only indices read as zero
    read_reg(3'd1, v); check("R3", "set index read", v, 8'h00);
    read_reg(3'd2, v); check("R3", "clear index read", v, 8'h00);

    // R10 one-cycle latency from status to irq (mask has bit 1)
    @(negedge clk); mode_fault = 1'b1;
    @(posedge clk); @(negedge clk); mode_fault = 1'b0;
    read_reg(3'd0, v); check("R10", "status bit1 latched", v, 8'h02);
    check("R10", "irq not yet", {7'd0, irq}, 8'h00);
    @(posedge clk); @(negedge clk);
    check("R10", "irq after one cycle", {7'd0, irq}, 8'h01);

    // R1 reset mid-run clears everything
    rst_n = 1'b0;
    #1;
    read_reg(3'd0, v); check("R1", "status mid reset", v, 8'h00);
    read_reg(3'd3, v); check("R1", "mask mid reset", v, 8'h00);
    read_reg(3'd4, v); check("R1", "wmark mid reset", v, 8'h01);
    check("R1", "irq mid reset", {7'd0, irq}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    summary();
  end

endmodule